// File: doc/BRIEF.md
# Register Busy Scoreboard for Three Fixed-Latency Units

This block keeps one busy bit for each of 32 general-purpose registers and decides, cycle by cycle, whether an instruction may issue. Three pipelined execution units sit behind it: an integer unit (3 cycles), a floating-point adder (5 cycles) and a floating-point multiplier (6 cycles). Each issue request carries two source register numbers, a destination register number and a unit code. The request is granted in the same cycle only if none of the three registers is waiting for a result.

When a request is granted, the destination's busy bit is set. The operation is then carried down a small per-unit delay line that matches the unit's depth. When it reaches the end, the block raises that unit's writeback strobe and clears the busy bit. Because busy state is tracked per register and not per unit, an independent instruction can issue and complete while a slower operation is still in flight. Register 0 is the constant-zero register and is never marked busy.

Top module: `regScoreboard`

## Requirements
- R1: While reset is held, and in the first cycle after it, every busy bit is 0 and no writeback strobe is raised.
- R2: Register 0 never shows as busy. An operation that targets register 0 leaves all busy bits unchanged, and register 0 used as a source or destination never blocks issue.
- R3: `issueGrant` is 1 exactly when `issueValid` is 1, `unitSel` is 0 (integer), 1 (fp add) or 2 (fp multiply), and none of `srcA`, `srcB` or `dst` has its busy bit set. The check is made combinationally in the same cycle.
- R4: After a grant in cycle T with a nonzero destination, that destination's bit in `busyVec` (bit index equals register number) reads 1 from cycle T+1 onward.
- R5: An integer operation granted in cycle T raises `wbStrobe[0]` in cycle T+3 only. Its destination busy bit reads 0 from cycle T+4.
- R6: An fp add granted in cycle T raises `wbStrobe[1]` in cycle T+5 only. Its destination busy bit reads 0 from cycle T+6.
- R7: An fp multiply granted in cycle T raises `wbStrobe[2]` in cycle T+6 only. Its destination busy bit reads 0 from cycle T+7.
- R8: An instruction with no dependence on in-flight results issues while a slower operation is still pending, and it may write back before that operation does.
- R9: When one register is cleared by a writeback in the same cycle that a different register is set by a grant, both changes take effect.
- R10: A refused request changes no busy bit and produces no writeback strobe. This covers unit code 3 and any request blocked by a busy register.
- R11: Each unit accepts one operation per cycle. Grants to the same unit in consecutive cycles produce writeback strobes in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An issue request is present |
| srcA | input | 5 | First source register number |
| srcB | input | 5 | Second source register number |
| dst | input | 5 | Destination register number |
| unitSel | input | 2 | Target unit: 0 integer, 1 fp add, 2 fp multiply, 3 none |
| issueGrant | output | 1 | Request accepted this cycle |
| busyVec | output | 32 | Busy bit per register, bit n for register n |
| wbStrobe | output | 3 | Writeback this cycle, bit per unit in unit-code order |

## Verification
Two things can happen in the same cycle: a writeback clearing one register and a new grant setting another. The bench makes this happen on purpose. It issues an fp add and then, exactly five cycles later, issues an integer operation to a different destination. The next cycle's `busyVec` must show the old bit cleared and the new bit set. Two or three units writing back in the same cycle also happens under the random stream. Every cycle, the bench compares all outputs against a behavioural model that uses countdowns per register and shift masks per unit.

// File: rtl/scbPkg.sv
package scbPkg;
  localparam int REG_COUNT = 32;
  localparam int IDX_W     = $clog2(REG_COUNT);
  localparam int NUM_UNITS = 3;
  localparam int UNIT_W    = $clog2(NUM_UNITS + 1);

  typedef logic [IDX_W-1:0] regIdx_t;

  typedef enum logic [UNIT_W-1:0] {
    UNIT_INT  = 2'd0,
    UNIT_FADD = 2'd1,
    UNIT_FMUL = 2'd2,
    UNIT_NONE = 2'd3
  } unitCode_e;

  // strobes from the decision logic to the busy/pipeline datapath
  typedef struct packed {
    logic                 setEn;
    regIdx_t              setIdx;
    logic [NUM_UNITS-1:0] unitLoad;
    regIdx_t              loadIdx;
  } scbStrobe_t;
endpackage

// File: rtl/scbControl.sv
module scbControl
  import scbPkg::*;
(
  input  logic                 issueValid,
  input  regIdx_t              srcA,
  input  regIdx_t              srcB,
  input  regIdx_t              dst,
  input  logic [UNIT_W-1:0]    unitSel,
  input  logic [REG_COUNT-1:0] busyVec,
  output logic                 issueGrant,
  output scbStrobe_t           strobe
);
  logic unitKnown;
  logic hazard;

  always_comb begin
    unitKnown  = (unitSel < UNIT_W'(NUM_UNITS));
    hazard     = busyVec[srcA] | busyVec[srcB] | busyVec[dst];
    issueGrant = issueValid & unitKnown & ~hazard;

    strobe.setEn    = issueGrant & (dst != '0);
    strobe.setIdx   = dst;
    strobe.loadIdx  = dst;
    strobe.unitLoad = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (issueGrant && (unitSel == UNIT_W'(u))) strobe.unitLoad[u] = 1'b1;
    end
  end
endmodule

// File: rtl/scbUnitPipe.sv
module scbUnitPipe
  import scbPkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    load,
  input  regIdx_t loadIdx,
  output logic    wbValid,
  output regIdx_t wbIdx
);
  logic    validQ [DEPTH];
  regIdx_t idxQ   [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < DEPTH; s++) begin
        validQ[s] <= 1'b0;
        idxQ[s]   <= '0;
      end
    end else begin
      validQ[0] <= load;
      idxQ[0]   <= loadIdx;
      for (int s = 1; s < DEPTH; s++) begin
        validQ[s] <= validQ[s-1];
        idxQ[s]   <= idxQ[s-1];
      end
    end
  end

  assign wbValid = validQ[DEPTH-1];
  assign wbIdx   = idxQ[DEPTH-1];
endmodule

// File: rtl/scbDatapath.sv
module scbDatapath
  import scbPkg::*;
#(
  parameter int LAT_INT  = 3,
  parameter int LAT_FADD = 5,
  parameter int LAT_FMUL = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  scbStrobe_t           strobe,
  output logic [REG_COUNT-1:0] busyVec,
  output logic [NUM_UNITS-1:0] wbStrobe
);
  regIdx_t              wbIdx [NUM_UNITS];
  logic [REG_COUNT-1:0] clrMask;
  logic [REG_COUNT-1:0] setMask;
  logic [REG_COUNT-1:0] busyQ;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : gUnit
    localparam int DEPTH = (u == 0) ? LAT_INT : (u == 1) ? LAT_FADD : LAT_FMUL;
    scbUnitPipe #(.DEPTH(DEPTH)) uPipe (
      .clk     (clk),
      .rstN    (rstN),
      .load    (strobe.unitLoad[u]),
      .loadIdx (strobe.loadIdx),
      .wbValid (wbStrobe[u]),
      .wbIdx   (wbIdx[u])
    );
  end

  always_comb begin
    clrMask = '0;
    setMask = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (wbStrobe[u]) clrMask[wbIdx[u]] = 1'b1;
    end
    if (strobe.setEn) setMask[strobe.setIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) busyQ <= '0;
    else       busyQ <= ((busyQ & ~clrMask) | setMask) & ~REG_COUNT'(1);
  end

  assign busyVec = busyQ;
endmodule

// File: rtl/regScoreboard.sv
module regScoreboard
  import scbPkg::*;
#(
  parameter int LAT_INT  = 3,
  parameter int LAT_FADD = 5,
  parameter int LAT_FMUL = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 issueValid,
  input  logic [IDX_W-1:0]     srcA,
  input  logic [IDX_W-1:0]     srcB,
  input  logic [IDX_W-1:0]     dst,
  input  logic [UNIT_W-1:0]    unitSel,
  output logic                 issueGrant,
  output logic [REG_COUNT-1:0] busyVec,
  output logic [NUM_UNITS-1:0] wbStrobe
);
  scbStrobe_t strobe;

  scbControl uCtrl (
    .issueValid (issueValid),
    .srcA       (srcA),
    .srcB       (srcB),
    .dst        (dst),
    .unitSel    (unitSel),
    .busyVec    (busyVec),
    .issueGrant (issueGrant),
    .strobe     (strobe)
  );

  scbDatapath #(
    .LAT_INT  (LAT_INT),
    .LAT_FADD (LAT_FADD),
    .LAT_FMUL (LAT_FMUL)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busyVec  (busyVec),
    .wbStrobe (wbStrobe)
  );
endmodule

// File: rtl/regScoreboardChecker.sv
module regScoreboardChecker
  import scbPkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 issueValid,
  input logic [IDX_W-1:0]     srcA,
  input logic [IDX_W-1:0]     srcB,
  input logic [IDX_W-1:0]     dst,
  input logic [UNIT_W-1:0]    unitSel,
  input logic                 issueGrant,
  input logic [REG_COUNT-1:0] busyVec,
  input logic [NUM_UNITS-1:0] wbStrobe
);
  assert_reg0_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busyVec[0]);

  assert_no_grant_on_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    issueGrant |-> (issueValid && !busyVec[srcA] && !busyVec[srcB] && !busyVec[dst]));

  assert_dst_marked_R4: assert property (@(posedge clk) disable iff (!rstN)
    (issueGrant && dst != '0) |=> busyVec[$past(dst)]);

  assert_clear_needs_wb_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((~busyVec & $past(busyVec)) != '0) |-> $past(|wbStrobe));

  assert_bad_unit_refused_R10: assert property (@(posedge clk) disable iff (!rstN)
    (unitSel == UNIT_W'(3)) |-> !issueGrant);

  assert_set_needs_grant_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((busyVec & ~$past(busyVec)) != '0) |-> $past(issueGrant));
endmodule

bind regScoreboard regScoreboardChecker uChk (
  .clk        (clk),
  .rstN       (rstN),
  .issueValid (issueValid),
  .srcA       (srcA),
  .srcB       (srcB),
  .dst        (dst),
  .unitSel    (unitSel),
  .issueGrant (issueGrant),
  .busyVec    (busyVec),
  .wbStrobe   (wbStrobe)
);

// File: tb/sim_regScoreboard.sv
module sim_regScoreboard;
  localparam int CLK_PERIOD = 10;
  localparam int LAT [3] = '{3, 5, 6};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [4:0]  srcA = '0, srcB = '0, dst = '0;
  logic [1:0]  unitSel = '0;
  logic        issueGrant;
  logic [31:0] busyVec;
  logic [2:0]  wbStrobe;

  int checkCount = 0;
  int failCount  = 0;

  // behavioural model: remaining busy cycles per register, writeback masks per unit
  int       busyCnt [32];
  logic [7:0] unitSh [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  regScoreboard u0 (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .srcA(srcA), .srcB(srcB),
    .dst(dst), .unitSel(unitSel), .issueGrant(issueGrant), .busyVec(busyVec),
    .wbStrobe(wbStrobe)
  );

  function automatic logic [31:0] modelBusy();
    logic [31:0] b = '0;
    for (int r = 0; r < 32; r++) b[r] = (busyCnt[r] > 0);
    return b;
  endfunction

  function automatic logic [2:0] modelWb();
    logic [2:0] w;
    for (int u = 0; u < 3; u++) w[u] = unitSh[u][0];
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input int a, input int b, input int d, input int u,
                      input string tag);
    logic [31:0] mb;
    bit expGrant;
    @(negedge clk);
    issueValid = v; srcA = 5'(a); srcB = 5'(b); dst = 5'(d); unitSel = 2'(u);
    #1;
    mb = modelBusy();
    expGrant = v && (u < 3) && !mb[a] && !mb[b] && !mb[d];
    check(issueGrant === expGrant, tag, "R3 grant", 32'(issueGrant), 32'(expGrant));
    check(busyVec === mb, tag, "R4 busyVec", busyVec, mb);
    check(wbStrobe === modelWb(), tag, "R5/R6/R7 wbStrobe", 32'(wbStrobe), 32'(modelWb()));
    @(posedge clk);
    for (int r = 0; r < 32; r++) if (busyCnt[r] > 0) busyCnt[r]--;
    for (int k = 0; k < 3; k++) unitSh[k] = unitSh[k] >> 1;
    if (expGrant) begin
      if (d != 0) busyCnt[d] = LAT[u];
      unitSh[u][LAT[u]-1] = 1'b1;
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failCount++;
    checkCount++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    for (int r = 0; r < 32; r++) busyCnt[r] = 0;
    for (int k = 0; k < 3; k++) unitSh[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(busyVec === '0, "R1", "reset busyVec", busyVec, '0);
    check(wbStrobe === '0, "R1", "reset wbStrobe", 32'(wbStrobe), '0);
    rstN = 1'b1;
    idle(1, "R1");

    // R3/R5: integer op, then a dependent request retried until it is granted
    step(1, 2, 3, 1, 0, "R5");
    for (int i = 0; i < 4; i++) step(1, 1, 0, 10, 0, "R5 R10 dependent retry");
    idle(3, "R5");

    // R6 and R7: single fp add and fp multiply
    step(1, 4, 5, 2, 1, "R6");
    idle(7, "R6");
    step(1, 4, 5, 3, 2, "R7");
    idle(8, "R7");

    // R8: slow multiply, then an independent integer op finishing first
    step(1, 6, 7, 4, 2, "R8");
    step(1, 8, 9, 5, 0, "R8");
    step(1, 4, 5, 11, 1, "R8 R10 blocked");
    idle(7, "R8");

    // R9: fp add clears r5 in the cycle an integer op sets r6
    step(1, 0, 0, 5, 1, "R9");
    idle(4, "R9");
    step(1, 0, 0, 6, 0, "R9");
    idle(5, "R9");

    // R11: back-to-back integer issues
    step(1, 0, 0, 7, 0, "R11");
    step(1, 0, 0, 8, 0, "R11");
    step(1, 0, 0, 9, 0, "R11");
    idle(5, "R11");

    // R2: register 0 as destination and sources
    step(1, 0, 0, 0, 2, "R2");
    step(1, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 12, 1, "R2");
    idle(7, "R2");

    // R10: unit code 3 and a request blocked only by its destination
    step(1, 1, 2, 13, 3, "R10");
    step(1, 0, 0, 14, 2, "R10");
    step(1, 1, 2, 14, 0, "R10");
    idle(7, "R10");

    // mixed stream: overlapping writebacks and all request shapes
    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 7), $urandom_range(0, 7),
           $urandom_range(0, 7), $urandom_range(0, 3), "R3 R9 mixed");
    idle(8, "R8");

    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule